// File: doc/BRIEF.md
# Serial Overhead Receiver with Idle-Gap Monitor

This block receives low-order path overhead, together with the remote error and remote defect indications, over an external three-wire serial link made up of a clock, a data line and a valid strobe. Both data and valid are sampled on the falling edge of the serial clock, and every register in the block updates on that edge. While valid is high, data bits shift in most significant bit first and a bit counter counts them. When valid drops after exactly the number of bits that the selected word type needs, the word is placed in the output register and a one-cycle done strobe tells the downstream insertion logic that a new value is ready.

The block also checks the sender's timing. Valid must stay low for at least eight serial clocks between transfers. Valid must also fall no later than the clock after the last expected bit. If either rule is broken, a sticky alarm flag is set and the transfer in progress is dropped. A mode input selects between the short word type (8 bits) and the long word type (16 bits). A clear input resets the sticky flags.

Top module: `ohs_rx`

## Requirements
- R1: While reset is asserted, the word output reads zero, and done, both error flags and the alarm are low. After reset, the first transfer is accepted with no gap check against an earlier transfer.
- R2: Data and valid are sampled only on falling edges of the serial clock. Any value they hold between two falling edges has no effect.
- R3: With the mode input at 0, a transfer of exactly 8 bits (MSB first) produces a zero-extended 8-bit word on the output. Done goes high for exactly one clock, on the falling edge at which valid is first seen low.
- R4: With the mode input at 1, a transfer of exactly 16 bits (MSB first) produces the 16-bit word and the same one-clock done pulse.
- R5: A transfer that ends with fewer bits than the selected length leaves the word output unchanged, gives no done pulse and raises no alarm.
- R6: If valid is seen high after fewer than 8 consecutive low samples following its previous high period, the gap error flag is set and that transfer is not committed.
- R7: A gap of exactly 8 low samples is legal, and the following transfer is committed.
- R8: If valid is still high on the sample after the bit counter has reached the selected length, the overrun error flag is set and the transfer is not committed.
- R9: Both error flags stay set until the clear input is sampled high, and they are cleared on that sample. A later error sets them again.
- R10: The alarm output is high exactly when at least one error flag is set.
- R11: The idle-gap count saturates, so an idle period of any length (300 clocks, for example) never causes a gap error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_in | input | 1 | Serial data, MSB first |
| sv_in | input | 1 | Valid strobe framing each transfer |
| long_mode | input | 1 | 0 selects 8-bit words, 1 selects 16-bit words |
| alarm_clr | input | 1 | Clears both sticky error flags when sampled high |
| word_out | output | 16 | Last committed word, zero-extended |
| word_done | output | 1 | One-clock pulse when word_out is updated |
| gap_err | output | 1 | Sticky: idle gap shorter than 8 clocks |
| ovr_err | output | 1 | Sticky: valid held past the expected bit count |
| alarm | output | 1 | High when either error flag is set |

## Verification
The receive path is exercised with an 8-bit word and a 16-bit word whose bit patterns are asymmetric, so a bit-order reversal or a mask that is off by one shows up in the result. Three kinds of bad transfer each probe a different rule: a short transfer (which must be dropped silently), an overlong transfer (overrun) and a transfer that arrives early (gap). Gaps of four clocks, exactly eight clocks and three hundred clocks separate an off-by-one error in the gap comparison from a counter that wraps around. A clear pulse followed by a fresh error confirms that the flags are sticky and can be set again.

// File: rtl/ohs_rx.sv
module ohs_rx #(
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 16,
  parameter int MIN_GAP   = 8
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                sd_in,
  input  logic                sv_in,
  input  logic                long_mode,
  input  logic                alarm_clr,
  output logic [LONG_LEN-1:0] word_out,
  output logic                word_done,
  output logic                gap_err,
  output logic                ovr_err,
  output logic                alarm
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic [LONG_LEN-1:0] shreg;
  logic [CW-1:0]       bitcnt;
  logic [GW-1:0]       gapcnt;
  logic                prev_v;
  logic                bad;

  logic [CW-1:0]       max_len;
  logic [LONG_LEN-1:0] mask;
  logic                rise, fall, gap_short, overrun, commit;

  assign max_len   = long_mode ? CW'(LONG_LEN) : CW'(SHORT_LEN);
  assign mask      = long_mode ? {LONG_LEN{1'b1}}
                               : {{(LONG_LEN-SHORT_LEN){1'b0}}, {SHORT_LEN{1'b1}}};
  assign rise      = sv_in & ~prev_v;
  assign fall      = ~sv_in & prev_v;
  assign gap_short = rise && (gapcnt < GW'(MIN_GAP));
  assign overrun   = sv_in && prev_v && (bitcnt == max_len);
  assign commit    = fall && !bad && (bitcnt == max_len);
  assign alarm     = gap_err | ovr_err;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bitcnt    <= '0;
      gapcnt    <= GW'(MIN_GAP);
      prev_v    <= 1'b0;
      bad       <= 1'b0;
      word_out  <= '0;
      word_done <= 1'b0;
      gap_err   <= 1'b0;
      ovr_err   <= 1'b0;
    end else begin
      prev_v    <= sv_in;
      word_done <= commit;
      if (commit) word_out <= shreg & mask;

      if (sv_in) begin
        gapcnt <= '0;
        if (rise) begin
          shreg  <= {shreg[LONG_LEN-2:0], sd_in};
          bitcnt <= CW'(1);
          bad    <= gap_short;
        end else if (overrun) begin
          bad <= 1'b1;
        end else begin
          shreg  <= {shreg[LONG_LEN-2:0], sd_in};
          bitcnt <= bitcnt + CW'(1);
        end
      end else begin
        bitcnt <= '0;
        if (gapcnt < GW'(MIN_GAP)) gapcnt <= gapcnt + GW'(1);
      end

      gap_err <= (gap_err & ~alarm_clr) | gap_short;
      ovr_err <= (ovr_err & ~alarm_clr) | overrun;
    end
  end
endmodule

// File: rtl/ohs_rx_chk.sv
module ohs_rx_chk #(
  parameter int W = 16
) (
  input logic         sclk,
  input logic         rst_n,
  input logic         sv_in,
  input logic         alarm_clr,
  input logic [W-1:0] word_out,
  input logic         word_done,
  input logic         gap_err,
  input logic         ovr_err
);
  a_r3_done_single: assert property (@(negedge sclk) disable iff (!rst_n)
    word_done |=> !word_done);

  a_r3_done_on_fall: assert property (@(negedge sclk) disable iff (!rst_n)
    word_done |-> (!$past(sv_in) && $past(sv_in, 2)));

  a_r5_word_hold: assert property (@(negedge sclk) disable iff (!rst_n)
    !$stable(word_out) |-> word_done);

  a_r6_gap_at_rise: assert property (@(negedge sclk) disable iff (!rst_n)
    $rose(gap_err) |-> ($past(sv_in) && !$past(sv_in, 2)));

  a_r8_ovr_while_valid: assert property (@(negedge sclk) disable iff (!rst_n)
    $rose(ovr_err) |-> ($past(sv_in) && $past(sv_in, 2)));

  a_r9_gap_sticky: assert property (@(negedge sclk) disable iff (!rst_n)
    (gap_err && !alarm_clr) |=> gap_err);

  a_r9_ovr_sticky: assert property (@(negedge sclk) disable iff (!rst_n)
    (ovr_err && !alarm_clr) |=> ovr_err);
endmodule

bind ohs_rx ohs_rx_chk #(.W(LONG_LEN)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .sv_in(sv_in), .alarm_clr(alarm_clr),
  .word_out(word_out), .word_done(word_done),
  .gap_err(gap_err), .ovr_err(ovr_err)
);

// File: tb/tb_ohs_rx.sv
`timescale 1ns/1ps
module tb_ohs_rx;
  logic sclk = 1'b0, rst_n = 1'b0, sd_in = 1'b0, sv_in = 1'b0;
  logic long_mode = 1'b0, alarm_clr = 1'b0;
  logic [15:0] word_out;
  logic word_done, gap_err, ovr_err, alarm;
  int nchk = 0, nerr = 0;
  bit running = 1'b0;

  always #2.5 sclk = ~sclk;

  ohs_rx dut (
    .sclk(sclk), .rst_n(rst_n), .sd_in(sd_in), .sv_in(sv_in),
    .long_mode(long_mode), .alarm_clr(alarm_clr), .word_out(word_out),
    .word_done(word_done), .gap_err(gap_err), .ovr_err(ovr_err), .alarm(alarm)
  );

  // behavioural reference, updated on each falling edge
  int m_bits, m_gap, m_acc, m_word;
  bit m_pv, m_bad, m_done, m_gerr, m_oerr;
  always @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      m_bits = 0; m_gap = 1000; m_acc = 0; m_word = 0;
      m_pv = 0; m_bad = 0; m_done = 0; m_gerr = 0; m_oerr = 0;
    end else begin
      int need;
      need = long_mode ? 16 : 8;
      m_done = 0;
      if (alarm_clr) begin m_gerr = 0; m_oerr = 0; end
      if (sv_in) begin
        if (!m_pv) begin
          m_bad = (m_gap < 8);
          if (m_bad) m_gerr = 1;
          m_bits = 1; m_acc = int'(sd_in);
        end else if (m_bits == need) begin
          m_bad = 1; m_oerr = 1;
        end else begin
          m_acc = m_acc * 2 + int'(sd_in); m_bits++;
        end
        m_gap = 0;
      end else begin
        if (m_pv && !m_bad && m_bits == need) begin
          m_word = m_acc % (1 << need); m_done = 1;
        end
        m_bits = 0; m_gap++;
      end
      m_pv = sv_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge sclk) if (running) begin
    chk("R3/R4 word_out vs model", 32'(word_out), 32'(m_word));
    chk("R3 word_done vs model", 32'(word_done), 32'(m_done));
    chk("R6 gap_err vs model", 32'(gap_err), 32'(m_gerr));
    chk("R8 ovr_err vs model", 32'(ovr_err), 32'(m_oerr));
    chk("R10 alarm vs model", 32'(alarm), 32'(m_gerr | m_oerr));
  end

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(posedge sclk); sv_in = 1'b0; sd_in = 1'b0;
    end
  endtask

  // returns at the rising edge where the commit (if any) is visible
  task automatic send(int n, int val, bit mode);
    for (int i = n - 1; i >= 0; i--) begin
      @(posedge sclk); long_mode = mode; sv_in = 1'b1; sd_in = val[i];
      #1.25 sd_in = ~sd_in;
      #0.5  sd_in = val[i];
    end
    @(posedge sclk); sv_in = 1'b0; sd_in = 1'b0;
    @(posedge sclk);
  endtask

  task automatic pulse_clr();
    @(posedge sclk); alarm_clr = 1'b1;
    @(posedge sclk); alarm_clr = 1'b0;
    @(posedge sclk);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge sclk);
    chk("R1 reset word_out", 32'(word_out), 0);
    chk("R1 reset word_done", 32'(word_done), 0);
    chk("R1 reset alarm", 32'({gap_err, ovr_err, alarm}), 0);
    rst_n = 1'b1;
    running = 1'b1;
    idle(4);

    // R3 and R2: 8-bit word, data glitches between falling edges
    send(8, 32'hA5, 1'b0);
    chk("R3 8-bit word", 32'(word_out), 32'h00A5);
    chk("R2 R3 done pulse", 32'(word_done), 1);
    @(posedge sclk);
    chk("R3 done one clock", 32'(word_done), 0);
    idle(6);

    // R4: 16-bit word
    send(16, 32'hC3F1, 1'b1);
    chk("R4 16-bit word", 32'(word_out), 32'hC3F1);
    chk("R4 done pulse", 32'(word_done), 1);
    idle(8);

    // R5: short transfer discarded
    send(5, 32'h1B, 1'b0);
    chk("R5 short word unchanged", 32'(word_out), 32'hC3F1);
    chk("R5 short no done", 32'(word_done), 0);
    chk("R5 short no alarm", 32'(alarm), 0);
    idle(6);

    // R7: exactly 8 low samples before this transfer
    send(8, 32'h3C, 1'b0);
    chk("R7 gap of 8 accepted", 32'(word_out), 32'h003C);
    chk("R7 no gap error", 32'(gap_err), 0);
    idle(2);

    // R6: gap of 4
    send(8, 32'h81, 1'b0);
    chk("R6 gap error set", 32'(gap_err), 1);
    chk("R6 word not committed", 32'(word_out), 32'h003C);
    chk("R10 alarm on gap", 32'(alarm), 1);
    idle(10);

    // R9: sticky across a good transfer, then cleared
    send(8, 32'h7E, 1'b0);
    chk("R9 gap flag sticky", 32'(gap_err), 1);
    chk("R9 good word still taken", 32'(word_out), 32'h007E);
    pulse_clr();
    chk("R9 gap flag cleared", 32'(gap_err), 0);
    chk("R10 alarm cleared", 32'(alarm), 0);
    idle(8);

    // R8: overrun in 8-bit mode
    send(9, 32'h155, 1'b0);
    chk("R8 overrun flag", 32'(ovr_err), 1);
    chk("R8 word not committed", 32'(word_out), 32'h007E);
    chk("R8 no done", 32'(word_done), 0);
    chk("R10 alarm on overrun", 32'(alarm), 1);
    idle(8);

    // R8 again in 16-bit mode, then R9 re-arm after clear
    pulse_clr();
    chk("R9 overrun cleared", 32'(ovr_err), 0);
    idle(6);
    send(17, 32'h1ABCD, 1'b1);
    chk("R9 overrun set again", 32'(ovr_err), 1);
    pulse_clr();

    // R11: very long idle
    idle(300);
    send(8, 32'h96, 1'b0);
    chk("R11 long idle no gap error", 32'(gap_err), 0);
    chk("R11 word after long idle", 32'(word_out), 32'h0096);
    idle(4);

    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule